// File: doc/BRIEF.md
# Sliding Window Wire Scratchpad

This block is the wire store for a streaming gate-evaluation engine. Every gate result gets the next sequential wire address and is written at the head of a window. The window holds at most DEPTH of the newest wires. A write that arrives when the window is full pushes the oldest wire out, and the window base moves up by one. The block keeps no tags. Whether a read hits or misses depends only on where its address lies relative to the window base and head.

There are two read ports for the engine's gate operands. An address inside the window is read from banks that interleave consecutive addresses. An address below the base is not looked up. It takes the next value from an out-of-range queue, which the compiler's stream has already filled in the same order as the misses. A wire that leaves the window goes out as one writeback beat, unless its write marked it as spent. A spent wire is dropped without any off-chip traffic.

Top module: `wire_window_spad`

## Requirements
- R1: After reset the window base and head are both 0, `rsp_valid` and `wb_valid` are low, and `oor_ready` is high.
- R2: Each accepted write stores its wire at address `win_head` and advances the head by one. A read accepted at an address in [`win_base`, `win_head`) returns that wire on `rsp_data0`/`rsp_data1` with `rsp_valid` high on the cycle after acceptance.
- R3: Address `a` is stored in bank `a mod NBANKS`. When both ports read in-window addresses in the same bank in one cycle, port 0 is served and `rd_stall[1]` is high. Reads in different banks are both served in the same cycle.
- R4: The window never holds more than DEPTH wires. A write accepted while `win_head - win_base == DEPTH` evicts the wire at `win_base`, and the base advances by one.
- R5: Evicting a non-spent wire raises `wb_valid` with `wb_addr` equal to the evicted address and `wb_data` equal to its value. While `wb_ready` is low, `wr_ready` stays low and the head and base stay unchanged.
- R6: Evicting a wire written with `wr_spent` high produces no writeback beat. The write is accepted even when `wb_ready` is low.
- R7: A read below `win_base` takes the head of the out-of-range queue, and values come out in push order. At most one value is taken per cycle. When both ports miss in the same cycle, port 0 is served and `rd_stall[1]` is high.
- R8: A read below `win_base` while the out-of-range queue is empty raises its stall. It produces no response and consumes nothing.
- R9: A read at or above `win_head`, which is a wire not yet produced, stalls.
- R10: The out-of-range queue holds OOR_DEPTH values. `oor_ready` is low when it is full, and a push offered then is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Gate result offered |
| wr_ready | output | 1 | Gate result accepted this cycle |
| wr_data | input | WIRE_W | Gate result value |
| wr_spent | input | 1 | Wire needs no writeback when evicted |
| rd_valid | input | 2 | Read request, one bit per port |
| rd_addr0 | input | ADDR_W | Port 0 wire address |
| rd_addr1 | input | ADDR_W | Port 1 wire address |
| rd_stall | output | 2 | Request not taken this cycle, hold it |
| rsp_valid | output | 2 | Read data valid, one bit per port |
| rsp_data0 | output | WIRE_W | Port 0 read data |
| rsp_data1 | output | WIRE_W | Port 1 read data |
| oor_valid | input | 1 | Out-of-range value offered |
| oor_ready | output | 1 | Queue has room |
| oor_data | input | WIRE_W | Out-of-range value |
| wb_valid | output | 1 | Eviction writeback beat |
| wb_ready | input | 1 | Writeback beat accepted |
| wb_addr | output | ADDR_W | Address of evicted wire |
| wb_data | output | WIRE_W | Value of evicted wire |
| win_base | output | ADDR_W | Oldest wire address held |
| win_head | output | ADDR_W | Next wire address to be written |

## Verification
The bench sweeps every pair of port addresses over a partly filled window. A bank decode that uses the wrong address bits would show up as a stall on non-conflicting pairs, or as wrong data on conflicting ones. It then slides the window across several laps, with spent and live wires interleaved. It throttles the writeback port on both kinds of eviction. A design that leaked spent wires, or let a write overtake a stalled writeback, would emit extra beats or move the head early. Finally it drives misses with an empty queue, a full queue, and a simultaneous double miss. A queue that returned data out of order, popped twice in one cycle, or answered from an empty store would break the expected value order.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
   typedef enum logic [1:0] {
      RK_HIT  = 2'd0,
      RK_OOR  = 2'd1,
      RK_PEND = 2'd2
   } rd_kind_e;

   function automatic rd_kind_e classify(input logic [63:0] addr,
                                         input logic [63:0] base,
                                         input logic [63:0] head);
      if (addr < base)       return RK_OOR;
      else if (addr >= head) return RK_PEND;
      else                   return RK_HIT;
   endfunction
endpackage

// File: rtl/wsp_bank.sv
module wsp_bank #(
   parameter int WIRE_W = 128,
   parameter int ROWS   = 256,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ROW_W-1:0]  wrow,
   input  logic [WIRE_W-1:0] wdata,
   input  logic              wspent,
   input  logic [ROW_W-1:0]  r0row,
   input  logic [ROW_W-1:0]  r1row,
   input  logic [ROW_W-1:0]  erow,
   output logic [WIRE_W-1:0] r0data,
   output logic [WIRE_W-1:0] r1data,
   output logic [WIRE_W-1:0] edata,
   output logic              espent
);
   logic [WIRE_W-1:0] mem [ROWS];
   logic [ROWS-1:0]   spent_q;

   always_ff @(posedge clk) begin
      if (we) begin
         mem[wrow]     <= wdata;
         spent_q[wrow] <= wspent;
      end
   end

   assign r0data = mem[r0row];
   assign r1data = mem[r1row];
   assign edata  = mem[erow];
   assign espent = spent_q[erow];
endmodule

// File: rtl/wsp_oorq.sv
module wsp_oorq #(
   parameter int W     = 128,
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_valid,
   output logic         push_ready,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head_data,
   output logic         empty
);
   logic [W-1:0]   mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [PTR_W:0]   cnt;
   logic             push_fire;

   assign push_ready = (cnt != (PTR_W+1)'(DEPTH));
   assign empty      = (cnt == '0);
   assign push_fire  = push_valid && push_ready;
   assign head_data  = mem[rp];

   always_ff @(posedge clk) begin
      if (push_fire) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_fire) wp <= wp + 1'b1;
         if (pop)       rp <= rp + 1'b1;
         case ({push_fire, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/wsp_ctrl.sv
module wsp_ctrl
   import wsp_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DEPTH  = 1024,
   parameter int NBANKS = 4,
   localparam int BANK_W = $clog2(NBANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [1:0]        rd_valid,
   input  logic [ADDR_W-1:0] rd_addr0,
   input  logic [ADDR_W-1:0] rd_addr1,
   input  logic              oor_empty,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] head,
   output logic              full,
   output logic [1:0]        rd_stall,
   output logic [1:0]        rd_accept,
   output logic [1:0]        rd_oor,
   output logic              pop
);
   rd_kind_e k0, k1;
   logic     same_bank;

   assign full = ((head - base) == ADDR_W'(DEPTH));

   always_comb begin
      k0 = classify(64'(rd_addr0), 64'(base), 64'(head));
      k1 = classify(64'(rd_addr1), 64'(base), 64'(head));
      same_bank = (rd_addr0[BANK_W-1:0] == rd_addr1[BANK_W-1:0]);

      rd_stall[0] = rd_valid[0] &&
                    ((k0 == RK_PEND) || ((k0 == RK_OOR) && oor_empty));
      rd_stall[1] = rd_valid[1] &&
                    ((k1 == RK_PEND) ||
                     ((k1 == RK_OOR) && (oor_empty || (rd_valid[0] && (k0 == RK_OOR)))) ||
                     ((k1 == RK_HIT) && rd_valid[0] && (k0 == RK_HIT) && same_bank));

      rd_accept = rd_valid & ~rd_stall;
      rd_oor    = {k1 == RK_OOR, k0 == RK_OOR};
      pop       = |(rd_accept & rd_oor);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         head <= '0;
      end else if (wr_fire) begin
         head <= head + 1'b1;
         if (full) base <= base + 1'b1;
      end
   end
endmodule

// File: rtl/wire_window_spad.sv
module wire_window_spad #(
   parameter int WIRE_W    = 128,
   parameter int NBANKS    = 4,
   parameter int DEPTH     = 1024,
   parameter int ADDR_W    = 20,
   parameter int OOR_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [WIRE_W-1:0] wr_data,
   input  logic              wr_spent,
   input  logic [1:0]        rd_valid,
   input  logic [ADDR_W-1:0] rd_addr0,
   input  logic [ADDR_W-1:0] rd_addr1,
   output logic [1:0]        rd_stall,
   output logic [1:0]        rsp_valid,
   output logic [WIRE_W-1:0] rsp_data0,
   output logic [WIRE_W-1:0] rsp_data1,
   input  logic              oor_valid,
   output logic              oor_ready,
   input  logic [WIRE_W-1:0] oor_data,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [WIRE_W-1:0] wb_data,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W-1:0] win_head
);
   localparam int BANK_W = $clog2(NBANKS);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int ROWS   = DEPTH / NBANKS;

   if (NBANKS < 2 || (1 << BANK_W) != NBANKS) begin : g_bad_banks
      $error("NBANKS must be a power of two of at least 2");
   end
   if ((1 << IDX_W) != DEPTH || ROWS < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two holding at least two rows per bank");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed log2(DEPTH)");
   end
   if (OOR_DEPTH < 2 || (1 << $clog2(OOR_DEPTH)) != OOR_DEPTH) begin : g_bad_oor
      $error("OOR_DEPTH must be a power of two of at least 2");
   end

   logic              full, wr_fire, pop, oor_empty, ev_spent;
   logic [1:0]        rd_accept, rd_oor;
   logic [WIRE_W-1:0] oor_head;
   logic [WIRE_W-1:0] bk_r0 [NBANKS];
   logic [WIRE_W-1:0] bk_r1 [NBANKS];
   logic [WIRE_W-1:0] bk_ev [NBANKS];
   logic [NBANKS-1:0] bk_sp;

   wsp_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .NBANKS(NBANKS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
      .rd_valid(rd_valid), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
      .oor_empty(oor_empty), .base(win_base), .head(win_head), .full(full),
      .rd_stall(rd_stall), .rd_accept(rd_accept), .rd_oor(rd_oor), .pop(pop)
   );

   wsp_oorq #(.W(WIRE_W), .DEPTH(OOR_DEPTH)) u_oorq (
      .clk(clk), .rst_n(rst_n), .push_valid(oor_valid), .push_ready(oor_ready),
      .push_data(oor_data), .pop(pop), .head_data(oor_head), .empty(oor_empty)
   );

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic we_b;
      assign we_b = wr_fire && (win_head[BANK_W-1:0] == BANK_W'(b));
      wsp_bank #(.WIRE_W(WIRE_W), .ROWS(ROWS)) u_bank (
         .clk(clk), .we(we_b),
         .wrow(win_head[IDX_W-1:BANK_W]), .wdata(wr_data), .wspent(wr_spent),
         .r0row(rd_addr0[IDX_W-1:BANK_W]), .r1row(rd_addr1[IDX_W-1:BANK_W]),
         .erow(win_base[IDX_W-1:BANK_W]),
         .r0data(bk_r0[b]), .r1data(bk_r1[b]), .edata(bk_ev[b]), .espent(bk_sp[b])
      );
   end

   assign ev_spent = bk_sp[win_base[BANK_W-1:0]];
   assign wb_valid = wr_valid && full && !ev_spent;
   assign wb_addr  = win_base;
   assign wb_data  = bk_ev[win_base[BANK_W-1:0]];
   assign wr_ready = !full || ev_spent || wb_ready;
   assign wr_fire  = wr_valid && wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= '0;
      else        rsp_valid <= rd_accept;
   end

   always_ff @(posedge clk) begin
      if (rd_accept[0])
         rsp_data0 <= rd_oor[0] ? oor_head : bk_r0[rd_addr0[BANK_W-1:0]];
      if (rd_accept[1])
         rsp_data1 <= rd_oor[1] ? oor_head : bk_r1[rd_addr1[BANK_W-1:0]];
   end
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
   parameter int NBANKS = 4,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [1:0]        rd_valid,
   input logic [ADDR_W-1:0] rd_addr0,
   input logic [ADDR_W-1:0] rd_addr1,
   input logic [1:0]        rd_stall,
   input logic [1:0]        rsp_valid,
   input logic              oor_valid,
   input logic              oor_ready,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr,
   input logic [ADDR_W-1:0] win_base,
   input logic [ADDR_W-1:0] win_head
);
   localparam int BANK_W = $clog2(NBANKS);

   logic [15:0] q_cnt;
   logic        full_now, pop0, pop1, hit0, hit1;

   assign full_now = ((win_head - win_base) == ADDR_W'(DEPTH));
   assign pop0 = rd_valid[0] && !rd_stall[0] && (rd_addr0 < win_base);
   assign pop1 = rd_valid[1] && !rd_stall[1] && (rd_addr1 < win_base);
   assign hit0 = (rd_addr0 >= win_base) && (rd_addr0 < win_head);
   assign hit1 = (rd_addr1 >= win_base) && (rd_addr1 < win_head);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_cnt <= '0;
      else q_cnt <= q_cnt + 16'(oor_valid && oor_ready) - 16'(pop0) - 16'(pop1);
   end

   p_head_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> (win_head == $past(win_head) + 1'b1));
   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[0] && !rd_stall[0]) |=> rsp_valid[0]);
   p_bank_conflict_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (&rd_valid && hit0 && hit1 && (rd_addr0[BANK_W-1:0] == rd_addr1[BANK_W-1:0]))
      |-> (rd_stall[1] && !rd_stall[0]));
   p_occupancy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_head - win_base) <= ADDR_W'(DEPTH));
   p_base_slides_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && full_now) |=> (win_base == $past(win_base) + 1'b1));
   p_wb_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_addr == win_base && full_now));
   p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |-> !wr_ready);
   p_single_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop0 && pop1));
   p_empty_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[0] && (rd_addr0 < win_base) && (q_cnt == 16'd0)) |-> rd_stall[0]);
   p_pending_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[1] && (rd_addr1 >= win_head)) |-> rd_stall[1]);
endmodule

bind wire_window_spad wsp_checker #(.NBANKS(NBANKS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
   .rd_valid(rd_valid), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
   .rd_stall(rd_stall), .rsp_valid(rsp_valid), .oor_valid(oor_valid),
   .oor_ready(oor_ready), .wb_valid(wb_valid), .wb_ready(wb_ready),
   .wb_addr(wb_addr), .win_base(win_base), .win_head(win_head)
);

// File: tb/wire_window_spad_tb.sv
module wire_window_spad_tb;
   localparam int WW = 16;
   localparam int NB = 4;
   localparam int DP = 16;
   localparam int AW = 10;
   localparam int OD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_spent = 1'b0, wr_ready;
   logic [WW-1:0] wr_data = '0;
   logic [1:0]    rd_valid = '0, rd_stall, rsp_valid;
   logic [AW-1:0] rd_addr0 = '0, rd_addr1 = '0;
   logic [WW-1:0] rsp_data0, rsp_data1;
   logic          oor_valid = 1'b0, oor_ready;
   logic [WW-1:0] oor_data = '0;
   logic          wb_valid, wb_ready = 1'b1;
   logic [AW-1:0] wb_addr, win_base, win_head;
   logic [WW-1:0] wb_data;

   int nchk = 0, nfail = 0;
   int exp_head = 0, exp_base = 0;

   always #5 clk = ~clk;

   wire_window_spad #(.WIRE_W(WW), .NBANKS(NB), .DEPTH(DP), .ADDR_W(AW), .OOR_DEPTH(OD)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .wr_spent(wr_spent), .rd_valid(rd_valid),
      .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_stall(rd_stall),
      .rsp_valid(rsp_valid), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
      .oor_valid(oor_valid), .oor_ready(oor_ready), .oor_data(oor_data),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
      .wb_data(wb_data), .win_base(win_base), .win_head(win_head)
   );

   function automatic logic [WW-1:0] wv(input int a);
      return WW'(a * 37 + 5);
   endfunction
   function automatic bit sp(input int a);
      return (a % 3) == 0;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   task automatic issue(input bit v0, input int a0, input bit v1, input int a1);
      rd_valid = {v1, v0};
      rd_addr0 = AW'(a0);
      rd_addr1 = AW'(a1);
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      rd_valid  = '0;
      oor_valid = 1'b0;
   endtask

   task automatic wr(input int hold);
      int h;
      bit full, exp_wb;
      h = exp_head;
      full = (exp_head - exp_base) == DP;
      wr_valid = 1'b1;
      wr_data  = wv(h);
      wr_spent = sp(h);
      #1;
      if (full) begin
         exp_wb = !sp(h - DP);
         chk(exp_wb ? "R4 live eviction beat" : "R6 spent eviction silent", wb_valid, exp_wb);
         if (exp_wb) begin
            chk("R5 wb_addr", wb_addr, h - DP);
            chk("R5 wb_data", wb_data, wv(h - DP));
         end
         if (hold > 0) begin
            wb_ready = 1'b0;
            #1;
            if (exp_wb) begin
               repeat (hold) begin
                  chk("R5 write held while wb blocked", wr_ready, 0);
                  @(posedge clk);
                  #1;
                  chk("R5 head frozen", win_head, h);
                  chk("R5 base frozen", win_base, exp_base);
               end
            end else begin
               chk("R6 spent write ignores wb_ready", wr_ready, 1);
            end
            wb_ready = 1'b1;
            #1;
         end
      end else begin
         chk("R4 no beat below capacity", wb_valid, 0);
      end
      chk("R2 write accepted", wr_ready, 1);
      @(posedge clk);
      #1;
      wr_valid = 1'b0;
      exp_head++;
      if (full) exp_base++;
      chk("R2 head advance", win_head, exp_head);
      chk("R4 base position", win_base, exp_base);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      #23;
      chk("R1 base at reset", win_base, 0);
      chk("R1 head at reset", win_head, 0);
      chk("R1 rsp_valid at reset", rsp_valid, 0);
      chk("R1 wb_valid at reset", wb_valid, 0);
      chk("R1 oor_ready at reset", oor_ready, 1);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R9: nothing written yet
      issue(1, 0, 0, 0);
      chk("R9 unwritten read stalls", rd_stall[0], 1);
      tick();
      chk("R9 no response", rsp_valid, 0);

      for (int i = 0; i < 10; i++) wr(0);

      // R2 single reads; R3 full pair sweep
      for (int a = 0; a < 10; a++) begin
         issue(1, a, 0, 0);
         chk("R2 hit not stalled", rd_stall[0], 0);
         tick();
         chk("R2 rsp_valid", rsp_valid, 2'b01);
         chk("R2 read data", rsp_data0, wv(a));
      end
      for (int a = 0; a < 10; a++) begin
         for (int b = 0; b < 10; b++) begin
            bit cf;
            cf = (a % NB) == (b % NB);
            issue(1, a, 1, b);
            chk("R3 port0 never stalls on hit", rd_stall[0], 0);
            chk("R3 port1 conflict stall", rd_stall[1], cf);
            tick();
            chk("R3 port0 data", rsp_data0, wv(a));
            chk("R3 port1 served", rsp_valid[1], !cf);
            if (!cf) chk("R3 port1 data", rsp_data1, wv(b));
            else begin
               issue(0, 0, 1, b);
               chk("R3 retry accepted", rd_stall[1], 0);
               tick();
               chk("R3 retry data", rsp_data1, wv(b));
            end
         end
      end

      // R4/R5/R6 slide the window several laps
      while (exp_head < 41) wr((exp_head == 17) ? 2 : (exp_head == 19) ? 1 : 0);
      chk("R4 window full", win_head - win_base, DP);

      issue(1, 30, 0, 0);
      tick();
      chk("R2 data after slide", rsp_data0, wv(30));

      // R8 empty queue
      issue(1, 24, 0, 0);
      chk("R8 empty queue stall", rd_stall[0], 1);
      tick();
      chk("R8 no response", rsp_valid, 0);

      // R10 fill queue
      for (int i = 0; i < OD; i++) begin
         oor_valid = 1'b1;
         oor_data  = WW'(16'hA000 + i);
         #1;
         chk("R10 room available", oor_ready, 1);
         tick();
      end
      #1;
      chk("R10 full queue not ready", oor_ready, 0);
      oor_valid = 1'b1;
      oor_data  = 16'hBEEF;
      tick();

      // R7 order and single pop
      issue(1, 5, 1, 20);
      chk("R7 port0 miss served", rd_stall[0], 0);
      chk("R7 second miss stalls", rd_stall[1], 1);
      tick();
      chk("R7 first value", rsp_data0, 16'hA000);
      chk("R7 one response", rsp_valid, 2'b01);
      issue(0, 0, 1, 20);
      tick();
      chk("R7 second value", rsp_data1, 16'hA001);
      issue(1, 30, 1, 3);
      chk("R7 hit plus miss both taken", rd_stall, 2'b00);
      tick();
      chk("R7 hit data", rsp_data0, wv(30));
      chk("R7 third value", rsp_data1, 16'hA002);
      chk("R10 room after pops", oor_ready, 1);
      issue(1, 24, 1, 26);
      tick();
      chk("R10 dropped push skipped", rsp_data0, 16'hA003);
      chk("R7 hit beside miss", rsp_data1, wv(26));
      issue(1, 1, 0, 0);
      chk("R8 drained queue stalls", rd_stall[0], 1);
      tick();
      chk("R8 no response after drain", rsp_valid, 0);

      // R9 pending reads
      issue(1, 41, 1, 45);
      chk("R9 head address stalls", rd_stall, 2'b11);
      tick();
      wr(0);
      issue(1, 41, 0, 0);
      chk("R9 produced wire readable", rd_stall[0], 0);
      tick();
      chk("R9 new wire data", rsp_data0, wv(41));

      summary();
      $finish;
   end
endmodule